// File: doc/BRIEF.md
# Two-Channel PCM Slot Shifter

This block places two audio channels at programmable bit offsets inside a PCM frame of up to 1024 bit clocks. It shifts transmit samples out MSB first and assembles receive samples MSB first. A separate timing generator supplies a one-cycle bit tick, the current bit index within the frame and a frame-start marker. The block exchanges 32-bit words with external transmit and receive FIFOs through a pop strobe and a push strobe. The transmit FIFO is show-ahead, so the head word is visible before it is popped.

Transmit and receive each have their own 32-bit configuration word. That word gives every channel an enable, a start bit index and a width of 8 to 32 bits. A packed option, chosen separately for each direction, carries both channels as two 16-bit halves of a single FIFO word. This halves the FIFO traffic for 16-bit audio.

Top module: `pcm_slot_shifter`

## Requirements
- R1: During reset and after it, before any bit tick, serOut, txPop, txUnderrun, rxPush and rxWord are all 0.
- R2: Each 32-bit configuration word holds channel 1 in bits [31:16] and channel 2 in bits [15:0]. Within each 16-bit half, bit 15 is the width extension, bit 14 is the enable, bits [13:4] are the start bit index (0 to 1023) and bits [3:0] are the width code.
- R3: A channel's width in bits is 8 plus the width code, plus 16 when the extension bit is set, and is capped at 32. For example, 24 bits is code 0 with the extension bit set.
- R4: On the tick whose bit index equals an enabled transmit channel's start index, the sample's MSB is driven, and the following ticks drive the remaining bits in MSB-first order. serOut is registered: it changes in the cycle after a tick and holds until the next tick.
- R5: On a tick outside every enabled transmit window, serOut is 0. A disabled channel neither drives data nor pops the FIFO.
- R6: txPop is high, combinationally, during the start tick of a transmit channel that needs a word, and only when txEmpty is low. Without packing, each enabled channel pops one word per frame.
- R7: If txEmpty is high at a start tick that needs a word, no pop occurs, the channel sends all zeros, and txUnderrun pulses for one cycle together with the first zero bit.
- R8: In transmit packed mode, only channel 1's start tick pops. Channel 1 sends the word's bits [15:0] and channel 2 sends bits [31:16] of that same word. On an underrun, both halves are zero.
- R9: A receive channel samples serIn on each tick of its window, starting at its start index. In the cycle after the last tick of the window, rxPush pulses for one cycle, and rxWord holds the sample right-aligned with its upper unused bits zero.
- R10: In receive packed mode, channel 1 completion pushes nothing. Channel 2 completion pushes one word with channel 2's low 16 bits in [31:16] and channel 1's low 16 bits in [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle tick per bit clock |
| bitPos | input | 10 | Bit index within the frame, valid with bitEn |
| frameStart | input | 1 | High with the tick of bit index 0; cancels open windows |
| txCfg | input | 32 | Transmit channel configuration |
| rxCfg | input | 32 | Receive channel configuration |
| txPacked | input | 1 | Two 16-bit transmit samples per FIFO word |
| rxPacked | input | 1 | Two 16-bit receive samples per FIFO word |
| txWord | input | 32 | Head word of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO empty |
| txPop | output | 1 | Consume the head transmit word |
| serOut | output | 1 | Serial transmit data |
| txUnderrun | output | 1 | Pulse when a channel started with no data |
| serIn | input | 1 | Serial receive data, sampled on ticks |
| rxWord | output | 32 | Assembled receive word |
| rxPush | output | 1 | rxWord valid for one cycle |

## Verification
A window counter that is off by one shows up at serOut one tick late. It either shifts every transmit bit or leaves a stray bit after the window, and this is visible in the cycle after the faulty tick. A wrong receive count moves rxPush one tick away from the window end and shifts rxWord by one bit at that push. A lost packed hold register corrupts the second half of the word at the next channel 2 boundary in either direction. The reference model predicts every serOut bit, every pop, every underrun and every push for each tick, and the bench compares against it in every cycle.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = 10;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int NCH    = 2;

  typedef struct packed {
    logic             ext;
    logic             en;
    logic [POS_W-1:0] pos;
    logic [3:0]       code;
  } chanCfgT;

  typedef struct packed {
    logic [NCH-1:0] txStart;
    logic [NCH-1:0] txBusy;
    logic [NCH-1:0] rxStart;
    logic [NCH-1:0] rxBusy;
    logic [NCH-1:0] rxLast;
  } strobeT;

  function automatic logic [CNT_W-1:0] widthOf(input chanCfgT c);
    logic [CNT_W:0] w;
    w = (CNT_W+1)'(8) + (CNT_W+1)'(c.code) + (c.ext ? (CNT_W+1)'(16) : '0);
    return (w > (CNT_W+1)'(WORD_W)) ? CNT_W'(WORD_W) : w[CNT_W-1:0];
  endfunction

  function automatic chanCfgT halfOf(input logic [WORD_W-1:0] cfg, input int ch);
    return (ch == 0) ? chanCfgT'(cfg[31:16]) : chanCfgT'(cfg[15:0]);
  endfunction
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [POS_W-1:0]  bitPos,
  input  logic              frameStart,
  input  logic [WORD_W-1:0] txCfg,
  input  logic [WORD_W-1:0] rxCfg,
  output strobeT            stb
);
  logic [1:0][NCH-1:0] startV, busyV, lastV;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      chanCfgT cfg;
      logic [CNT_W-1:0] remain;
      assign cfg = halfOf((d == 0) ? txCfg : rxCfg, c);
      assign startV[d][c] = bitEn && cfg.en && (bitPos == cfg.pos);
      assign busyV[d][c]  = bitEn && (remain != '0) && !frameStart && !startV[d][c];
      assign lastV[d][c]  = busyV[d][c] && (remain == CNT_W'(1));

      always_ff @(posedge clk) begin
        if (!rstN)                  remain <= '0;
        else if (startV[d][c])      remain <= widthOf(cfg) - CNT_W'(1);
        else if (bitEn && frameStart) remain <= '0;
        else if (busyV[d][c])       remain <= remain - CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb.txStart = startV[0];
    stb.txBusy  = busyV[0];
    stb.rxStart = startV[1];
    stb.rxBusy  = busyV[1];
    stb.rxLast  = lastV[1];
  end
endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  strobeT            stb,
  input  logic [WORD_W-1:0] txCfg,
  input  logic [WORD_W-1:0] rxCfg,
  input  logic              txPacked,
  input  logic              rxPacked,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txEmpty,
  input  logic              serIn,
  output logic              txPop,
  output logic              serOut,
  output logic              txUnderrun,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush
);
  localparam int HALF_W = WORD_W / 2;

  logic [CNT_W-1:0]   txW0, txW1;
  logic [4:0]         msb0, msb1;
  logic [WORD_W-1:0]  fresh0, fresh1, sh0, sh1;
  logic [HALF_W-1:0]  holdHi, holdLo;
  logic [WORD_W-1:0]  acc [NCH];
  logic [WORD_W-1:0]  nxtAcc [NCH];
  logic               needWord, txBit;

  assign txW0 = widthOf(halfOf(txCfg, 0));
  assign txW1 = widthOf(halfOf(txCfg, 1));
  assign msb0 = 5'(txW0 - CNT_W'(1));
  assign msb1 = 5'(txW1 - CNT_W'(1));

  always_comb begin
    fresh0   = txEmpty ? '0 : (txPacked ? {{HALF_W{1'b0}}, txWord[HALF_W-1:0]} : txWord);
    fresh1   = txPacked ? {{HALF_W{1'b0}}, holdHi} : (txEmpty ? '0 : txWord);
    needWord = stb.txStart[0] || (stb.txStart[1] && !txPacked);
    txPop    = needWord && !txEmpty;
    if (stb.txStart[0])      txBit = fresh0[msb0];
    else if (stb.txBusy[0])  txBit = sh0[WORD_W-1];
    else if (stb.txStart[1]) txBit = fresh1[msb1];
    else if (stb.txBusy[1])  txBit = sh1[WORD_W-1];
    else                     txBit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut     <= 1'b0;
      txUnderrun <= 1'b0;
      sh0        <= '0;
      sh1        <= '0;
      holdHi     <= '0;
    end else begin
      txUnderrun <= needWord && txEmpty;
      if (bitEn) serOut <= txBit;
      if (stb.txStart[0])     sh0 <= fresh0 << (CNT_W'(WORD_W + 1) - txW0);
      else if (stb.txBusy[0]) sh0 <= sh0 << 1;
      if (stb.txStart[1])     sh1 <= fresh1 << (CNT_W'(WORD_W + 1) - txW1);
      else if (stb.txBusy[1]) sh1 <= sh1 << 1;
      if (stb.txStart[0] && txPacked)
        holdHi <= txEmpty ? '0 : txWord[WORD_W-1:HALF_W];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) nxtAcc[c] = {acc[c][WORD_W-2:0], serIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) acc[c] <= '0;
      holdLo <= '0;
      rxWord <= '0;
      rxPush <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (stb.rxStart[c])     acc[c] <= {{(WORD_W-1){1'b0}}, serIn};
        else if (stb.rxBusy[c]) acc[c] <= nxtAcc[c];
      end
      if (stb.rxLast[0]) begin
        if (rxPacked) holdLo <= nxtAcc[0][HALF_W-1:0];
        else begin
          rxPush <= 1'b1;
          rxWord <= nxtAcc[0];
        end
      end
      if (stb.rxLast[1]) begin
        rxPush <= 1'b1;
        rxWord <= rxPacked ? {nxtAcc[1][HALF_W-1:0], holdLo} : nxtAcc[1];
      end
    end
  end

  logic unusedRx;
  assign unusedRx = ^rxCfg;
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter
  import pcm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [POS_W-1:0]  bitPos,
  input  logic              frameStart,
  input  logic [WORD_W-1:0] txCfg,
  input  logic [WORD_W-1:0] rxCfg,
  input  logic              txPacked,
  input  logic              rxPacked,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txEmpty,
  output logic              txPop,
  output logic              serOut,
  output logic              txUnderrun,
  input  logic              serIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush
);
  strobeT stb;

  pcm_slot_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitPos(bitPos),
    .frameStart(frameStart), .txCfg(txCfg), .rxCfg(rxCfg), .stb(stb)
  );

  pcm_slot_dp i_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .stb(stb),
    .txCfg(txCfg), .rxCfg(rxCfg), .txPacked(txPacked), .rxPacked(rxPacked),
    .txWord(txWord), .txEmpty(txEmpty), .serIn(serIn),
    .txPop(txPop), .serOut(serOut), .txUnderrun(txUnderrun),
    .rxWord(rxWord), .rxPush(rxPush)
  );
endmodule

// File: rtl/pcm_slot_shifter_chk.sv
module pcm_slot_shifter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        bitEn,
  input logic [31:0] txCfg,
  input logic        txEmpty,
  input logic        txPop,
  input logic        serOut,
  input logic        txUnderrun,
  input logic        rxPush
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty); // R6
  AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> bitEn); // R6
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(serOut)); // R4
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> !serOut); // R7
  AST_UNDERRUN_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> !$past(txPop)); // R7
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (!txCfg[30] && !txCfg[14]) |-> !txPop); // R5
  AST_PUSH_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> $past(bitEn)); // R9
endmodule

bind pcm_slot_shifter pcm_slot_shifter_chk i_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .txCfg(txCfg), .txEmpty(txEmpty),
  .txPop(txPop), .serOut(serOut), .txUnderrun(txUnderrun), .rxPush(rxPush)
);

// File: tb/test_pcm_slot_shifter.sv
module test_pcm_slot_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic [9:0]  bitPos = '0;
  logic        frameStart = 1'b0;
  logic [31:0] txCfg = '0, rxCfg = '0;
  logic        txPacked = 1'b0, rxPacked = 1'b0;
  logic [31:0] txWord = '0;
  logic        txEmpty = 1'b1;
  logic        serIn = 1'b0;
  logic        txPop, serOut, txUnderrun, rxPush;
  logic [31:0] rxWord;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [31:0] txQ[$];
  logic [15:0] mHoldHi = '0, mHoldLo = '0;
  bit expTx[1024], inWin[1024], expPop[1024], expUnd[1024], expPush[1024], rxBits[1024];
  logic [31:0] expRx[1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_slot_shifter i_pcm_slot_shifter (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitPos(bitPos), .frameStart(frameStart),
    .txCfg(txCfg), .rxCfg(rxCfg), .txPacked(txPacked), .rxPacked(rxPacked),
    .txWord(txWord), .txEmpty(txEmpty), .txPop(txPop), .serOut(serOut),
    .txUnderrun(txUnderrun), .serIn(serIn), .rxWord(rxWord), .rxPush(rxPush)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] half(bit en, int pos, int w);
    bit ext = (w >= 24);
    int code = w - 8 - (ext ? 16 : 0);
    return {ext, en, 10'(pos), 4'(code)};
  endfunction

  function automatic int widthOfHalf(logic [15:0] h);
    int w = 8 + h[3:0] + (h[15] ? 16 : 0);
    return (w > 32) ? 32 : w;
  endfunction

  task automatic refresh();
    txEmpty = (txQ.size() == 0);
    txWord  = txEmpty ? 32'h0 : txQ[0];
  endtask

  // Behavioural prediction of a whole frame from the requirements
  task automatic predict(int len);
    logic [31:0] mq[$];
    mq = txQ;
    for (int p = 0; p < len; p++) begin
      expTx[p] = 0; inWin[p] = 0; expPop[p] = 0; expUnd[p] = 0; expPush[p] = 0;
      expRx[p] = 0; rxBits[p] = 1'($urandom);
    end
    for (int p = 0; p < len; p++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] h = (c == 0) ? txCfg[31:16] : txCfg[15:0];
        if (h[14] && h[13:4] == 10'(p)) begin
          int w = widthOfHalf(h);
          logic [31:0] s = 0;
          if (txPacked && c == 1) s = {16'h0, mHoldHi};
          else if (mq.size() == 0) begin
            expUnd[p] = 1;
            if (txPacked) mHoldHi = 0;
          end else begin
            logic [31:0] wd = mq.pop_front();
            expPop[p] = 1;
            if (txPacked) begin s = {16'h0, wd[15:0]}; mHoldHi = wd[31:16]; end
            else s = wd;
          end
          for (int k = 0; k < w; k++)
            if (p + k < len) begin expTx[p+k] = s[w-1-k]; inWin[p+k] = 1; end
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      logic [15:0] h = (c == 0) ? rxCfg[31:16] : rxCfg[15:0];
      if (h[14]) begin
        int w = widthOfHalf(h);
        int pos = h[13:4];
        logic [31:0] v = 0;
        for (int k = 0; k < w; k++) v = {v[30:0], rxBits[pos+k]};
        if (rxPacked && c == 0) mHoldLo = v[15:0];
        else begin
          expPush[pos+w-1] = 1;
          expRx[pos+w-1] = rxPacked ? {v[15:0], mHoldLo} : v;
        end
      end
    end
  endtask

  task automatic runFrame(int len, string txTag, string rxTag);
    predict(len);
    for (int p = 0; p < len; p++) begin
      bit popped;
      @(negedge clk);
      bitEn = 1; bitPos = 10'(p); frameStart = (p == 0); serIn = rxBits[p];
      #1;
      chk({"R6 pop ", txTag}, 32'(txPop), 32'(expPop[p]));
      popped = txPop;
      @(negedge clk);
      bitEn = 0; frameStart = 0;
      if (popped) void'(txQ.pop_front());
      refresh();
      chk(inWin[p] ? txTag : "R5", 32'(serOut), 32'(expTx[p]));
      chk("R7", 32'(txUnderrun), 32'(expUnd[p]));
      chk(rxTag, 32'(rxPush), 32'(expPush[p]));
      if (expPush[p]) chk({rxTag, " word"}, rxWord, expRx[p]);
      @(negedge clk);
      chk("R4 hold", 32'(serOut), 32'(expTx[p]));
      chk({rxTag, " single"}, 32'(rxPush), 32'h0);
    end
  endtask

  task automatic setup(logic [31:0] tc, logic [31:0] rc, bit tp, bit rp, int nWords);
    txCfg = tc; rxCfg = rc; txPacked = tp; rxPacked = rp;
    txQ.delete();
    for (int i = 0; i < nWords; i++) txQ.push_back($urandom);
    refresh();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 serOut", 32'(serOut), 0);
    chk("R1 pop", 32'(txPop), 0);
    chk("R1 push", 32'(rxPush), 0);
    chk("R1 word", rxWord, 0);
    chk("R1 underrun", 32'(txUnderrun), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after", 32'(serOut), 0);

    // 16-bit slots delayed by one bit, unpacked
    setup({half(1, 1, 16), half(1, 33, 16)}, {half(1, 1, 16), half(1, 33, 16)}, 0, 0, 4);
    repeat (2) runFrame(64, "R4", "R9");
    // 24-bit via extension bit
    setup({half(1, 0, 24), half(1, 32, 24)}, {half(1, 0, 24), half(1, 32, 24)}, 0, 0, 4);
    repeat (2) runFrame(64, "R3", "R3 R9");
    // 32-bit full words and capped code
    setup({half(1, 0, 32), 16'hC00F | 16'(32 << 4)}, {half(1, 0, 32), half(1, 32, 32)}, 0, 0, 4);
    repeat (2) runFrame(64, "R3", "R9");
    // packed both directions
    setup({half(1, 0, 16), half(1, 16, 16)}, {half(1, 0, 16), half(1, 16, 16)}, 1, 1, 3);
    repeat (3) runFrame(32, "R8", "R10");
    // underrun, packed then unpacked
    setup({half(1, 0, 16), half(1, 16, 16)}, {half(1, 0, 16), half(1, 16, 16)}, 1, 1, 0);
    runFrame(32, "R7 R8", "R10");
    setup({half(1, 0, 16), half(1, 16, 16)}, {half(1, 2, 12), half(0, 16, 16)}, 0, 0, 1);
    runFrame(32, "R7", "R9");
    // channel 2 disabled
    setup({half(1, 4, 20), half(0, 40, 20)}, {half(0, 4, 20), half(1, 40, 20)}, 0, 0, 2);
    runFrame(64, "R5", "R9");
    // far offsets across a long frame
    setup({half(1, 100, 8), half(1, 700, 20)}, {half(1, 300, 8), half(1, 1000, 23)}, 0, 0, 2);
    runFrame(1024, "R2", "R2 R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R1-watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule